// File: doc/BRIEF.md
# Bus Ready and Reset Synchronizer

This block gathers several bus-ready indications, each one accepted only while its own active-low bus enable is asserted, and turns them into a single ready signal timed to the processor clock. A run-time mode input chooses between a short path (one falling-edge register) and a safer path (a rising-edge register followed by a falling-edge register). The ready output can only change on a falling clock edge, so a processor sampling on the rising edge always sees a settled value.

The same block cleans up an asynchronous, active-low reset request. Its active-high reset output rises at once when the request goes low and falls only after a fixed number of falling clock edges once the request is released. A single-bus system ties every enable low, so every ready input is always accepted.

Top module: `rdy_rst_sync`

## Requirements
- R1: Ready input 0 (`bus_rdy_i[0]`) has no effect on `cpu_rdy_o` while enable 0 (`bus_en_n_i[0]`) is high; with the enable low, a high ready input drives `cpu_rdy_o` high.
- R2: Ready input 1 (`bus_rdy_i[1]`) has no effect on `cpu_rdy_o` while enable 1 (`bus_en_n_i[1]`) is high; with the enable low, a high ready input drives `cpu_rdy_o` high.
- R3: The qualified ready is the OR of all enabled ready terms: one enabled high input is enough, and the output stays high while at least one remains.
- R4: With `sync_mode_i` = 0 (two-stage), the qualified ready is sampled on a rising edge and reaches `cpu_rdy_o` on the following falling edge; a change made just after a rising edge appears 1.5 clock periods later.
- R5: With `sync_mode_i` = 1 (single-stage), the qualified ready is sampled directly on a falling edge; a change made just after a rising edge appears at the next falling edge.
- R6: Removing the qualified ready lowers `cpu_rdy_o` with the same latency as asserting it in the selected mode, and `cpu_rdy_o` changes only on falling edges.
- R7: While `rst_n` is low at a clock edge, `cpu_rdy_o` is driven low at the next falling edge regardless of the ready inputs.
- R8: `cpu_rst_o` goes high as soon as `rst_req_n_i` goes low, without waiting for a clock edge.
- R9: After `rst_req_n_i` returns high, `cpu_rst_o` stays high for RST_STAGES-1 falling edges and goes low on the RST_STAGES-th (default 2).
- R10: `cpu_rst_o` stays high for as long as `rst_req_n_i` is low, across any number of clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset of the ready path |
| sync_mode_i | input | 1 | 0 = two synchronizer stages, 1 = single stage |
| bus_rdy_i | input | NUM_BUS | Active-high ready per bus |
| bus_en_n_i | input | NUM_BUS | Active-low enable qualifying each ready input |
| rst_req_n_i | input | 1 | Asynchronous active-low reset request |
| cpu_rdy_o | output | 1 | Synchronized ready to the processor |
| cpu_rst_o | output | 1 | Active-high reset to the processor, released on a falling edge |

## Verification
The hardest case to reach is telling the two synchronizer depths apart, because both settle to the same level and differ only in the half-cycle in which the output moves. The bench changes the qualified ready just after a rising edge and then samples just after each following falling edge and rising edge. The single-stage path has then already moved at the first falling edge, while the two-stage path holds through that edge and the next rising edge. The reset release is checked edge by edge in the same way, so that it lands on exactly the configured falling edge.

// File: rtl/rdy_rst_pkg.sv
// Shared types for the ready/reset synchronizer.
package rdy_rst_pkg;
    // Synchronizer depth selection, encoded as the mode pin level.
    typedef enum logic {
        SYNC_DOUBLE = 1'b0,
        SYNC_SINGLE = 1'b1
    } sync_mode_e;
endpackage

// File: rtl/rdy_qualify.sv
// Gates each bus ready with its active-low enable and ORs the results.
// Assumes: purely combinational; the inputs may be asynchronous to clk.
module rdy_qualify #(
    parameter int NUM_BUS = 2
) (
    input  logic [NUM_BUS-1:0] bus_rdy_i,
    input  logic [NUM_BUS-1:0] bus_en_n_i,
    output logic               qual_o
);
    logic [NUM_BUS-1:0] term;

    // One gated term per bus.
    for (genvar g = 0; g < NUM_BUS; g++) begin : g_term
        assign term[g] = bus_rdy_i[g] & ~bus_en_n_i[g];
    end

    // Any accepted ready completes the transfer.
    always_comb qual_o = |term;
endmodule

// File: rtl/rdy_sync.sv
// Brings the qualified ready into the clock domain with one or two stages.
// Assumes: the output may change only on falling edges; rst_n is sampled
// synchronously on both edges.
module rdy_sync
    import rdy_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic qual_i,
    output logic rdy_o
);
    logic       stage_rise;
    sync_mode_e mode;

    always_comb mode = sync_mode_e'(mode_i);

    // First stage of the two-stage path, sampled on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_rise <= 1'b0;
        else        stage_rise <= qual_i;
    end

    // Output stage on the falling edge, source chosen by the mode.
    always_ff @(negedge clk) begin
        if (!rst_n)                   rdy_o <= 1'b0;
        else if (mode == SYNC_SINGLE) rdy_o <= qual_i;
        else                          rdy_o <= stage_rise;
    end
endmodule

// File: rtl/rst_sync.sv
// Turns an asynchronous active-low reset request into an active-high reset
// that sets at once and releases on a falling edge.
// Assumes: RST_STAGES >= 1; release takes RST_STAGES falling edges.
module rst_sync #(
    parameter int RST_STAGES = 2
) (
    input  logic clk,
    input  logic req_n_i,
    output logic rst_o
);
    logic [RST_STAGES-1:0] chain;

    // Asynchronous set, zeros shifted in on each falling edge once released.
    always_ff @(negedge clk or negedge req_n_i) begin
        if (!req_n_i) chain <= '1;
        else          chain <= chain << 1;
    end

    // The last flop drives the reset output.
    always_comb rst_o = chain[RST_STAGES-1];
endmodule

// File: rtl/rdy_rst_sync.sv
// Top level: qualified bus ready synchronizer plus reset synchronizer.
// Assumes: clk is the processor clock; rst_n resets only the ready path.
module rdy_rst_sync #(
    parameter int NUM_BUS    = 2,
    parameter int RST_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_mode_i,
    input  logic [NUM_BUS-1:0] bus_rdy_i,
    input  logic [NUM_BUS-1:0] bus_en_n_i,
    input  logic               rst_req_n_i,
    output logic               cpu_rdy_o,
    output logic               cpu_rst_o
);
    logic qual;

    rdy_qualify #(.NUM_BUS(NUM_BUS)) u_qual (
        .bus_rdy_i  (bus_rdy_i),
        .bus_en_n_i (bus_en_n_i),
        .qual_o     (qual)
    );

    rdy_sync u_rdy (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (sync_mode_i),
        .qual_i (qual),
        .rdy_o  (cpu_rdy_o)
    );

    rst_sync #(.RST_STAGES(RST_STAGES)) u_rst (
        .clk     (clk),
        .req_n_i (rst_req_n_i),
        .rst_o   (cpu_rst_o)
    );
endmodule

// File: rtl/rdy_rst_sync_chk.sv
// Checker for rdy_rst_sync; models the qualified ready from the ports.
module rdy_rst_sync_chk #(
    parameter int NUM_BUS = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync_mode_i,
    input logic [NUM_BUS-1:0] bus_rdy_i,
    input logic [NUM_BUS-1:0] bus_en_n_i,
    input logic               rst_req_n_i,
    input logic               cpu_rdy_o,
    input logic               cpu_rst_o
);
    logic m_qual;
    logic m_rise;

    // Port-level model of the qualified ready.
    always_comb m_qual = |(bus_rdy_i & ~bus_en_n_i);

    // Model of the rising-edge sample used by the two-stage path.
    always_ff @(posedge clk) m_rise <= rst_n ? m_qual : 1'b0;

    AST_RDY_SINGLE: assert property (@(negedge clk) disable iff (!rst_n)
        (sync_mode_i && rst_n) |=> (cpu_rdy_o == $past(m_qual))); // R5
    AST_RDY_DOUBLE: assert property (@(negedge clk) disable iff (!rst_n)
        (!sync_mode_i && rst_n) |=> (cpu_rdy_o == $past(m_rise))); // R4
    AST_RST_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
        !rst_req_n_i |-> cpu_rst_o); // R10
    AST_RST_RELEASE: assert property (@(negedge clk) disable iff (!rst_n)
        $fell(cpu_rst_o) |-> rst_req_n_i); // R9
endmodule

bind rdy_rst_sync rdy_rst_sync_chk #(.NUM_BUS(NUM_BUS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_mode_i (sync_mode_i),
    .bus_rdy_i   (bus_rdy_i),
    .bus_en_n_i  (bus_en_n_i),
    .rst_req_n_i (rst_req_n_i),
    .cpu_rdy_o   (cpu_rdy_o),
    .cpu_rst_o   (cpu_rst_o)
);

// File: tb/sim_rdy_rst_sync.sv
module sim_rdy_rst_sync;
    localparam int NB  = 2;
    localparam int RST = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode;
    logic [NB-1:0] rdy;
    logic [NB-1:0] en_n;
    logic          req_n;
    logic          cpu_rdy;
    logic          cpu_rst;
    int            checks = 0;
    int            errors = 0;
    bit            done   = 1'b0;

    always #4 clk = ~clk;

    rdy_rst_sync #(.NUM_BUS(NB), .RST_STAGES(RST)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_mode_i (mode),
        .bus_rdy_i   (rdy),
        .bus_en_n_i  (en_n),
        .rst_req_n_i (req_n),
        .cpu_rdy_o   (cpu_rdy),
        .cpu_rst_o   (cpu_rst)
    );

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        check(cpu_rdy, 1'b0, "R7 ready low in reset");
        check(cpu_rst, 1'b1, "R10 reset held while request low");
    endtask

    task automatic t_gate0();
        rdy = 2'b01; en_n = 2'b11; settle();
        check(cpu_rdy, 1'b0, "R1 ready0 ignored when enable0 high");
        en_n = 2'b10; settle();
        check(cpu_rdy, 1'b1, "R1 ready0 accepted when enable0 low");
        rdy = 2'b00; en_n = 2'b11; settle();
    endtask

    task automatic t_gate1();
        rdy = 2'b10; en_n = 2'b11; settle();
        check(cpu_rdy, 1'b0, "R2 ready1 ignored when enable1 high");
        en_n = 2'b01; settle();
        check(cpu_rdy, 1'b1, "R2 ready1 accepted when enable1 low");
        rdy = 2'b00; en_n = 2'b11; settle();
    endtask

    task automatic t_or();
        en_n = 2'b00; rdy = 2'b11; settle();
        check(cpu_rdy, 1'b1, "R3 both ready");
        rdy = 2'b10; settle();
        check(cpu_rdy, 1'b1, "R3 one of two remains");
        rdy = 2'b00; settle();
        check(cpu_rdy, 1'b0, "R3 none ready");
    endtask

    task automatic t_single();
        mode = 1'b1; en_n = 2'b00; rdy = 2'b00; settle();
        @(posedge clk); #1 rdy = 2'b01;
        @(negedge clk); #1;
        check(cpu_rdy, 1'b1, "R5 single stage rise at next falling edge");
        @(posedge clk); #1 rdy = 2'b00;
        @(negedge clk); #1;
        check(cpu_rdy, 1'b0, "R6 single stage removal latency");
    endtask

    task automatic t_double();
        mode = 1'b0; en_n = 2'b00; rdy = 2'b00; settle();
        @(posedge clk); #1 rdy = 2'b10;
        @(negedge clk); #1;
        check(cpu_rdy, 1'b0, "R4 two stage not yet at first falling edge");
        @(posedge clk); #1;
        check(cpu_rdy, 1'b0, "R6 output steady across rising edge");
        @(negedge clk); #1;
        check(cpu_rdy, 1'b1, "R4 two stage rise after 1.5 periods");
        @(posedge clk); #1 rdy = 2'b00;
        @(negedge clk); #1;
        check(cpu_rdy, 1'b1, "R6 two stage still high at first falling edge");
        @(negedge clk); #1;
        check(cpu_rdy, 1'b0, "R6 two stage removal latency");
    endtask

    task automatic t_sync_reset();
        mode = 1'b1; en_n = 2'b00; rdy = 2'b01; settle();
        check(cpu_rdy, 1'b1, "R7 ready high before reset");
        @(posedge clk); #1 rst_n = 1'b0;
        @(negedge clk); #1;
        check(cpu_rdy, 1'b0, "R7 ready cleared by rst_n");
        @(posedge clk); #1 rst_n = 1'b1;
        rdy = 2'b00; settle();
    endtask

    task automatic t_req();
        check(cpu_rst, 1'b0, "R9 reset released beforehand");
        @(posedge clk); #2 req_n = 1'b0;
        #1;
        check(cpu_rst, 1'b1, "R8 asserts without clock edge");
        repeat (4) @(negedge clk);
        #1;
        check(cpu_rst, 1'b1, "R10 held across edges");
        @(posedge clk); #1 req_n = 1'b1;
        for (int i = 0; i < RST - 1; i++) begin
            @(negedge clk); #1;
            check(cpu_rst, 1'b1, "R9 still asserted before final edge");
        end
        @(negedge clk); #1;
        check(cpu_rst, 1'b0, "R9 released on final falling edge");
    endtask

    initial begin
        rst_n = 1'b0; mode = 1'b0; rdy = '0; en_n = '1; req_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        t_reset();
        @(posedge clk); #1 rst_n = 1'b1; req_n = 1'b1;
        repeat (RST + 1) @(negedge clk);
        #1;
        t_gate0();
        t_gate1();
        t_or();
        t_single();
        t_double();
        t_sync_reset();
        t_req();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule